// File: doc/BRIEF.md
# Three-Phase Gate Output Sequencer

This block produces the six gate-drive levels of a three-phase inverter bridge: a high-side and a low-side signal for each of the phases U, V and W. Software stages two 6-bit patterns in two holding registers over a small register bus. A transfer trigger copies both patterns into an output stage. From then on each phase drives its level from the first pattern, and it moves to the second pattern when the one-shot pulse input of that phase falls. Each phase has its own one-shot input, so the three phases switch independently. A transfer trigger always restarts the sequence.

A protection path puts all six pins into high impedance. This happens when a synchronized active-low fault input is seen low while the cutoff is armed. The cutoff is held in a sticky latch, so a one-cycle fault pulse still trips it. The cutoff is released only after the fault input is back high and software has disarmed it. Software can change the arming bit only while a separate protect bit is set.

Top module: `phase_gate_sequencer`

## Requirements
- R1: Register address 0 is holding pattern A and address 1 is holding pattern B. Within each, bit 0 is U, bit 1 is U-bar, bit 2 is V, bit 3 is V-bar, bit 4 is W and bit 5 is W-bar.
- R2: Bits 7:6 of both pattern registers ignore writes and always read back as zero.
- R3: A stored bit of 0 means the active level, and `gate_lvl` drives 1 for it. A stored bit of 1 means the inactive level, and `gate_lvl` drives 0 for it.
- R4: When `xfer_trig` is sampled high at a clock edge, both patterns are copied into the output stage. From that edge on, all three phases drive pattern A.
- R5: A falling edge on `os_pulse[p]` is a sample of 0 that follows a sample of 1. It switches only phase p (bits 2p and 2p+1) to its pattern B value from the next edge on. The phases are independent.
- R6: A read of address 0 or address 1 returns, in bits 5:0, the pattern that the output stage is currently driving. It does not return the written holding value.
- R7: When a transfer trigger and a one-shot falling edge come in the same cycle, the transfer wins and every phase restarts on the new pattern A.
- R8: Address 2 bit 0 arms the cutoff. While it is armed, a low on `fault_n` passes a two-flop synchronizer and latches the cutoff. `gate_oe` then goes to all zeros on the third clock edge after the low is sampled. A single-cycle low pulse is enough to trip it.
- R9: A latched cutoff clears only when the synchronized fault input is high and the arming bit is 0. It stays latched if either condition is missing.
- R10: Writes to address 2 take effect only while address 3 bit 0 (protect) is 1; otherwise the arming bit is unchanged. Address 3 is always writable.
- R11: After reset both patterns, the output stage, the arming bit and the protect bit are zero. `gate_oe` is all ones and `gate_lvl` is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| xfer_trig | input | 1 | Transfer trigger |
| os_pulse | input | 3 | One-shot pulses, bit 0 U, bit 1 V, bit 2 W |
| fault_n | input | 1 | Asynchronous active-low fault |
| gate_lvl | output | 6 | Gate levels, 1 means active |
| gate_oe | output | 6 | Per-pin output enable, 0 means high impedance |

## Verification
A transfer trigger and a one-shot falling edge can land on the same clock edge. The directed case raises one phase's one-shot, then drops it in the same cycle that the trigger is pulsed. It expects every phase, including the one that saw the edge, to show the new pattern A. Random stimulus hits the same collision often, because triggers and toggling one-shots are both frequent. A cycle model in the bench judges every cycle. A second overlap happens when the fault clears and software disarms in the same window. The release is checked against the two-condition rule.

// File: rtl/phase_gate_sequencer.sv
module phase_gate_sequencer #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       xfer_trig,
  input  logic [2:0] os_pulse,
  input  logic       fault_n,
  output logic [5:0] gate_lvl,
  output logic [5:0] gate_oe
);
  localparam int NPH = 3;
  localparam int NPIN = 2 * NPH;

  logic [NPIN-1:0] buf0_q, buf1_q, stg0_q, stg1_q, live;
  logic [NPH-1:0]  sel_q, os_prev_q, os_fall;
  logic            cut_en_q, prot_q, cut_lat_q;
  logic [SYNC_STAGES-1:0] flt_sync_q;
  logic            fault_ok;
  logic            unused_hi;

  assign unused_hi = ^wdata[7:6];
  assign os_fall   = os_prev_q & ~os_pulse;
  assign fault_ok  = flt_sync_q[SYNC_STAGES-1];

  for (genvar p = 0; p < NPH; p++) begin : g_phase
    assign live[2*p+1:2*p] = sel_q[p] ? stg1_q[2*p+1:2*p] : stg0_q[2*p+1:2*p];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         sel_q[p] <= 1'b0;
      else if (xfer_trig) sel_q[p] <= 1'b0;
      else if (os_fall[p]) sel_q[p] <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf0_q   <= '0;
      buf1_q   <= '0;
      cut_en_q <= 1'b0;
      prot_q   <= 1'b0;
    end else if (wr_en) begin
      case (addr)
        2'd0: buf0_q <= wdata[NPIN-1:0];
        2'd1: buf1_q <= wdata[NPIN-1:0];
        2'd2: if (prot_q) cut_en_q <= wdata[0];
        default: prot_q <= wdata[0];
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg0_q    <= '0;
      stg1_q    <= '0;
      os_prev_q <= '0;
    end else begin
      os_prev_q <= os_pulse;
      if (xfer_trig) begin
        stg0_q <= buf0_q;
        stg1_q <= buf1_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flt_sync_q <= '1;
      cut_lat_q  <= 1'b0;
    end else begin
      flt_sync_q <= {flt_sync_q[SYNC_STAGES-2:0], fault_n};
      if (cut_en_q && !fault_ok)      cut_lat_q <= 1'b1;
      else if (!cut_en_q && fault_ok) cut_lat_q <= 1'b0;
    end
  end

  assign gate_lvl = ~live;
  assign gate_oe  = {NPIN{~cut_lat_q}};

  always_comb begin
    case (addr)
      2'd0, 2'd1: rdata = {2'b00, live};
      2'd2:       rdata = {7'd0, cut_en_q};
      default:    rdata = {7'd0, prot_q};
    endcase
  end
endmodule

module phase_gate_sequencer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [1:0] addr,
  input logic [7:0] rdata,
  input logic       xfer_trig,
  input logic [5:0] gate_lvl,
  input logic [5:0] gate_oe,
  input logic [5:0] buf0_q,
  input logic [2:0] os_fall,
  input logic       fault_ok,
  input logic       cut_en_q,
  input logic       prot_q
);
  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[7:6] == 2'b00);
  a_r4_trigger_loads_a: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_trig |=> gate_lvl == ~$past(buf0_q));
  a_r5_hold_without_event: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer_trig && os_fall == 3'b000) |=> $stable(gate_lvl));
  a_r8_cutoff_trips: assert property (@(posedge clk) disable iff (!rst_n)
    (cut_en_q && !fault_ok) |=> gate_oe == 6'h00);
  a_r9_cutoff_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_oe == 6'h00 && !(fault_ok && !cut_en_q)) |=> gate_oe == 6'h00);
  a_r10_protect_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd2 && !prot_q) |=> $stable(cut_en_q));
endmodule

bind phase_gate_sequencer phase_gate_sequencer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .rdata(rdata),
  .xfer_trig(xfer_trig), .gate_lvl(gate_lvl), .gate_oe(gate_oe),
  .buf0_q(buf0_q), .os_fall(os_fall), .fault_ok(fault_ok),
  .cut_en_q(cut_en_q), .prot_q(prot_q)
);

// File: tb/phase_gate_sequencer_test.sv
`timescale 1ns/1ps
module phase_gate_sequencer_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, xfer_trig = 1'b0, fault_n = 1'b1;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0, rdata;
  logic [2:0] os_pulse = 3'd0;
  logic [5:0] gate_lvl, gate_oe;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  logic [5:0] m_b0, m_b1, m_s0, m_s1;
  logic [2:0] m_sel, m_prev;
  logic m_cut, m_prot, m_f1, m_f2, m_lat;

  always #2.5 clk = ~clk;

  phase_gate_sequencer uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .xfer_trig(xfer_trig), .os_pulse(os_pulse),
    .fault_n(fault_n), .gate_lvl(gate_lvl), .gate_oe(gate_oe));

  function automatic logic [5:0] exp_live();
    logic [5:0] v;
    for (int p = 0; p < 3; p++) begin
      v[2*p]   = m_sel[p] ? m_s1[2*p]   : m_s0[2*p];
      v[2*p+1] = m_sel[p] ? m_s1[2*p+1] : m_s0[2*p+1];
    end
    return v;
  endfunction

  function automatic logic [7:0] exp_rdata(logic [1:0] a);
    if (a < 2) return {2'b00, exp_live()};
    if (a == 2) return {7'd0, m_cut};
    return {7'd0, m_prot};
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_b0 = 0; m_b1 = 0; m_s0 = 0; m_s1 = 0; m_sel = 0; m_prev = 0;
    m_cut = 0; m_prot = 0; m_f1 = 1; m_f2 = 1; m_lat = 0;
  endtask

  task automatic model_step();
    logic [2:0] fall;
    logic [5:0] ob0, ob1;
    logic oc, of2;
    ob0 = m_b0; ob1 = m_b1; oc = m_cut; of2 = m_f2;
    fall = m_prev & ~os_pulse;
    if (wr_en) begin
      case (addr)
        2'd0: m_b0 = wdata[5:0];
        2'd1: m_b1 = wdata[5:0];
        2'd2: if (m_prot) m_cut = wdata[0];
        default: m_prot = wdata[0];
      endcase
    end
    if (xfer_trig) begin m_s0 = ob0; m_s1 = ob1; m_sel = 0; end
    else m_sel = m_sel | fall;
    if (oc && !of2) m_lat = 1;
    else if (!oc && of2) m_lat = 0;
    m_f2 = m_f1; m_f1 = fault_n; m_prev = os_pulse;
  endtask

  task automatic cycle();
    @(posedge clk);
    model_step();
    @(negedge clk);
    check("R3/R4/R5 gate_lvl", {2'b0, gate_lvl}, {2'b0, ~exp_live()});
    check("R8/R9 gate_oe", {2'b0, gate_oe}, {2'b0, m_lat ? 6'h00 : 6'h3F});
    check("R6/R10 rdata", rdata, exp_rdata(addr));
  endtask

  task automatic idle();
    wr_en = 0; xfer_trig = 0;
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    wr_en = 1; addr = a; wdata = d; cycle(); wr_en = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    check("R11 reset gate_lvl", {2'b0, gate_lvl}, 8'h3F);
    check("R11 reset gate_oe", {2'b0, gate_oe}, 8'h3F);
    check("R11 reset rdata", rdata, 8'h00);

    wr(2'd3, 8'h01);
    wr(2'd0, 8'hC5);
    addr = 2'd0; cycle();
    wr(2'd1, 8'hFA);
    xfer_trig = 1; cycle(); xfer_trig = 0;
    check("R3 R4 pattern A after trigger", {2'b0, gate_lvl}, 8'h3A);
    addr = 2'd1; cycle();
    check("R2 R6 readback of stage", rdata, 8'h05);
    os_pulse = 3'b001; cycle();
    os_pulse = 3'b000; cycle();
    check("R1 R5 U switches to pattern B", {2'b0, gate_lvl}, 8'h39);
    os_pulse = 3'b010; cycle();
    os_pulse = 3'b000; xfer_trig = 1; cycle(); xfer_trig = 0;
    check("R7 trigger beats falling edge", {2'b0, gate_lvl}, 8'h3A);

    wr(2'd3, 8'h00);
    wr(2'd2, 8'h01);
    addr = 2'd2; cycle();
    check("R10 protected arm ignored", rdata, 8'h00);
    fault_n = 0; repeat (4) cycle(); fault_n = 1;
    check("R10 no cutoff when unarmed", {2'b0, gate_oe}, 8'h3F);
    repeat (3) cycle();

    wr(2'd3, 8'h01);
    wr(2'd2, 8'h01);
    fault_n = 0; cycle(); fault_n = 1;
    repeat (3) cycle();
    check("R8 short pulse trips cutoff", {2'b0, gate_oe}, 8'h00);
    fault_n = 0; repeat (3) cycle();
    wr(2'd2, 8'h00);
    repeat (2) cycle();
    check("R9 held while fault low", {2'b0, gate_oe}, 8'h00);
    fault_n = 1; repeat (4) cycle();
    check("R9 released after both", {2'b0, gate_oe}, 8'h3F);

    for (int i = 0; i < 4000; i++) begin
      wr_en = ($urandom % 4) == 0;
      addr = 2'($urandom);
      wdata = 8'($urandom);
      xfer_trig = ($urandom % 6) == 0;
      if (($urandom % 2) == 0) os_pulse = 3'($urandom);
      fault_n = ($urandom % 40) != 0;
      if (i % 200 == 199) begin
        xfer_trig = 1; os_pulse = 3'b000;
      end
      cycle();
    end
    idle();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule